// File: doc/BRIEF.md
# Fill-and-rotate cyclic shift network

This block applies a cyclic rotation to a group of z signed 8-bit soft values. The group size z can be 24, 32, 48 or 96. One fixed barrel rotator, as wide as the largest group, serves every group size. A fill stage first copies the z valid lanes across the full rotator width, so that input lane i also appears at positions i+z, i+2z and so on. After rotation by the selected amount, the lowest z output lanes hold the rotated group, and the lanes above them carry no meaning. The result passes through a single register stage, and the valid strobe is delayed by the same amount.

The block has two ways to set the rotation. In direct mode, each beat is rotated by its required shift. In incremental mode, the input group is assumed to be already rotated by the previous beat's required shift. The block then applies only the difference between the two, modulo z, so no separate de-rotation pass is needed. A restart input clears the remembered shift at the start of a frame or an iteration.

Top module: `rfn_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, out_vld is 0 and out_data is all zeros.
- R2: Each beat with in_vld high produces exactly one out_vld pulse one clock later. A cycle with in_vld low produces out_vld low one clock later.
- R3: In direct mode (in_incr = 0), output lane k for k < z equals input lane (k + s) mod z, where s is the reduced shift. Lane 0 is in_data[7:0], lane k is in_data[8k+7:8k], and lane values are passed through unchanged as 8-bit two's complement.
- R4: in_zsel selects the group size: 0 gives z = 24, 1 gives z = 32, 2 gives z = 48 and 3 gives z = 96.
- R5: The 7-bit in_shift is reduced modulo z before it is used, so a shift of z or more acts like in_shift mod z.
- R6: In incremental mode (in_incr = 1), the applied shift is (s − p) mod z. Here s is the current reduced shift and p is the reduced shift of the most recent earlier valid beat, in either mode.
- R7: A cycle with in_restart high sets p to 0. If in_restart and in_vld are both high in the same cycle, that beat uses p = 0, and its own shift then becomes p for the next beat.
- R8: When in_vld is low, out_data keeps the value of the most recent beat.
- R9: Input lanes at positions z and above have no effect on output lanes below z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Input beat valid |
| in_incr | input | 1 | 1 = incremental mode, 0 = direct mode |
| in_restart | input | 1 | Clears the remembered previous shift |
| in_zsel | input | 2 | Group size code |
| in_shift | input | 7 | Required rotation amount |
| in_data | input | 768 | 96 lanes of 8 bits, lane 0 in the low bits |
| out_vld | output | 1 | Output beat valid |
| out_data | output | 768 | Rotated lanes; only lanes below z are meaningful |

## Verification
Direct-mode beats are sent for all four group sizes, with shifts of 0, a small value, z−1, exactly z and 127. These patterns separate a correct modulo reduction and wrap point from an off-by-one or unreduced shift. Random lane data, including the unused upper lanes, catches any leak from lanes above z. Incremental chains that move the shift both up and down exercise the modular difference, including the wrap through zero. A restart given alone, and a restart given together with a valid beat, show whether the remembered shift is cleared at the right point. Idle gaps between beats check that the output is held and that valid is not repeated.

// File: rtl/rfn_pkg.sv
package rfn_pkg;
   typedef enum logic [1:0] {
      ZS_24 = 2'd0,
      ZS_32 = 2'd1,
      ZS_48 = 2'd2,
      ZS_96 = 2'd3
   } zsel_e;
endpackage

// File: rtl/rfn_shift_ctl.sv
module rfn_shift_ctl #(
   parameter int SW = 7,
   parameter int Z0 = 24,
   parameter int Z1 = 32,
   parameter int Z2 = 48,
   parameter int Z3 = 96
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic          incr,
   input  logic          restart,
   input  logic [1:0]    zsel,
   input  logic [SW-1:0] shift,
   output logic [SW-1:0] zval,
   output logic [SW-1:0] red,
   output logic [SW-1:0] amt
);
   import rfn_pkg::*;
   localparam int RED_ITER = ((2**SW) + Z0 - 1) / Z0;

   logic [SW-1:0] prev_q;
   logic [SW-1:0] prev_eff;
   zsel_e         zs;

   assign zs = zsel_e'(zsel);

   always_comb begin
      case (zs)
         ZS_24:   zval = SW'(Z0);
         ZS_32:   zval = SW'(Z1);
         ZS_48:   zval = SW'(Z2);
         default: zval = SW'(Z3);
      endcase
   end

   always_comb begin
      red = shift;
      for (int it = 0; it < RED_ITER; it++) begin
         if (red >= zval) red = red - zval;
      end
   end

   assign prev_eff = restart ? '0 : prev_q;

   always_comb begin
      if (!incr)                amt = red;
      else if (red >= prev_eff) amt = red - prev_eff;
      else                      amt = red + zval - prev_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= '0;
      else if (vld)     prev_q <= red;
      else if (restart) prev_q <= '0;
   end
endmodule

// File: rtl/rfn_fill.sv
module rfn_fill #(
   parameter int DW   = 8,
   parameter int ZMAX = 96,
   parameter int Z0   = 24,
   parameter int Z1   = 32,
   parameter int Z2   = 48
) (
   input  logic [1:0]         zsel,
   input  logic [ZMAX*DW-1:0] din,
   output logic [ZMAX*DW-1:0] dout
);
   import rfn_pkg::*;
   zsel_e zs;
   assign zs = zsel_e'(zsel);

   for (genvar p = 0; p < ZMAX; p++) begin : g_port
      localparam int P0 = p % Z0;
      localparam int P1 = p % Z1;
      localparam int P2 = p % Z2;
      always_comb begin
         case (zs)
            ZS_24:   dout[p*DW +: DW] = din[P0*DW +: DW];
            ZS_32:   dout[p*DW +: DW] = din[P1*DW +: DW];
            ZS_48:   dout[p*DW +: DW] = din[P2*DW +: DW];
            default: dout[p*DW +: DW] = din[p*DW +: DW];
         endcase
      end
   end
endmodule

// File: rtl/rfn_barrel.sv
module rfn_barrel #(
   parameter int DW   = 8,
   parameter int ZMAX = 96,
   parameter int SW   = 7
) (
   input  logic [ZMAX*DW-1:0] din,
   input  logic [SW-1:0]      amt,
   output logic [ZMAX*DW-1:0] dout
);
   localparam int W      = ZMAX * DW;
   localparam int STAGES = $clog2(ZMAX);

   always_comb begin
      dout = din;
      for (int j = 0; j < STAGES; j++) begin
         if (amt[j]) begin
            dout = (dout >> (((1 << j) % ZMAX) * DW)) |
                   (dout << (W - ((1 << j) % ZMAX) * DW));
         end
      end
   end
endmodule

// File: rtl/rfn_top.sv
module rfn_top #(
   parameter int DW   = 8,
   parameter int ZMAX = 96,
   parameter int SW   = 7,
   parameter int Z0   = 24,
   parameter int Z1   = 32,
   parameter int Z2   = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic               in_incr,
   input  logic               in_restart,
   input  logic [1:0]         in_zsel,
   input  logic [SW-1:0]      in_shift,
   input  logic [ZMAX*DW-1:0] in_data,
   output logic               out_vld,
   output logic [ZMAX*DW-1:0] out_data
);
   if (ZMAX % Z0 != 0 || ZMAX % Z1 != 0 || ZMAX % Z2 != 0) begin : g_bad_div
      $error("group sizes must divide ZMAX");
   end
   if ((2**SW) <= ZMAX || SW < $clog2(ZMAX)) begin : g_bad_sw
      $error("SW too narrow for ZMAX");
   end

   logic [SW-1:0]      zval;
   logic [SW-1:0]      red;
   logic [SW-1:0]      amt;
   logic [ZMAX*DW-1:0] filled;
   logic [ZMAX*DW-1:0] rotated;

   rfn_shift_ctl #(.SW(SW), .Z0(Z0), .Z1(Z1), .Z2(Z2), .Z3(ZMAX)) u_ctl (
      .clk(clk), .rst_n(rst_n), .vld(in_vld), .incr(in_incr),
      .restart(in_restart), .zsel(in_zsel), .shift(in_shift),
      .zval(zval), .red(red), .amt(amt)
   );

   rfn_fill #(.DW(DW), .ZMAX(ZMAX), .Z0(Z0), .Z1(Z1), .Z2(Z2)) u_fill (
      .zsel(in_zsel), .din(in_data), .dout(filled)
   );

   rfn_barrel #(.DW(DW), .ZMAX(ZMAX), .SW(SW)) u_rot (
      .din(filled), .amt(amt), .dout(rotated)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_data <= rotated;
      end
   end
endmodule

// File: rtl/rfn_chk.sv
module rfn_chk #(
   parameter int DW   = 8,
   parameter int ZMAX = 96,
   parameter int SW   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_vld,
   input logic               in_incr,
   input logic               in_restart,
   input logic [1:0]         in_zsel,
   input logic [SW-1:0]      in_shift,
   input logic [ZMAX*DW-1:0] in_data,
   input logic               out_vld,
   input logic [ZMAX*DW-1:0] out_data,
   input logic [SW-1:0]      zval,
   input logic [SW-1:0]      red,
   input logic [SW-1:0]      amt
);
   // R2
   vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_data));
   // R5
   amt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> (amt < zval && red < zval));
   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_incr && in_restart) |-> amt == red);
   // R3
   direct96_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_incr && in_zsel == 2'd3 && in_shift < SW'(ZMAX)) |=>
      out_data[DW-1:0] == $past(in_data[in_shift*DW +: DW]));
endmodule

bind rfn_top rfn_chk #(.DW(DW), .ZMAX(ZMAX), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_incr(in_incr),
   .in_restart(in_restart), .in_zsel(in_zsel), .in_shift(in_shift),
   .in_data(in_data), .out_vld(out_vld), .out_data(out_data),
   .zval(zval), .red(red), .amt(amt)
);

// File: tb/rfn_top_tb.sv
module rfn_top_tb;
   localparam int DW = 8;
   localparam int ZMAX = 96;
   localparam int W = ZMAX * DW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_vld = 1'b0;
   logic         in_incr = 1'b0;
   logic         in_restart = 1'b0;
   logic [1:0]   in_zsel = 2'd0;
   logic [6:0]   in_shift = '0;
   logic [W-1:0] in_data = '0;
   logic         out_vld;
   logic [W-1:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int bprev = 0;

   logic [W-1:0] exp_q[$];
   int           z_q[$];
   string        tag_q[$];

   always #4 clk = ~clk;

   rfn_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_incr(in_incr),
      .in_restart(in_restart), .in_zsel(in_zsel), .in_shift(in_shift),
      .in_data(in_data), .out_vld(out_vld), .out_data(out_data)
   );

   function automatic int zof(input logic [1:0] c);
      case (c)
         2'd0: return 24;
         2'd1: return 32;
         2'd2: return 48;
         default: return 96;
      endcase
   endfunction

   task automatic send(input logic [1:0] zc, input int sh, input bit incr,
                       input bit rs, input string tag);
      int z, r, p, a;
      logic [W-1:0] d, e;
      z = zof(zc);
      r = sh % z;
      p = rs ? 0 : bprev;
      a = incr ? (r - p + z) % z : r;
      bprev = r;
      for (int i = 0; i < ZMAX; i++) d[i*DW +: DW] = DW'($urandom);
      e = '0;
      for (int k = 0; k < z; k++) e[k*DW +: DW] = d[((k + a) % z)*DW +: DW];
      @(negedge clk);
      in_vld = 1'b1; in_incr = incr; in_restart = rs;
      in_zsel = zc; in_shift = 7'(sh); in_data = d;
      exp_q.push_back(e); z_q.push_back(z); tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0; in_restart = 1'b0;
         in_data = {ZMAX{8'hA5}}; in_shift = 7'd77;
      end
   endtask

   task automatic restart_only();
      @(negedge clk);
      in_vld = 1'b0; in_restart = 1'b1;
      bprev = 0;
   endtask

   // monitor / scoreboard
   logic [W-1:0] last_out;
   bit have_last = 0;
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk); #1;
         if (out_vld) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R2: unexpected out_vld, actual 1 expected 0");
            end else begin
               logic [W-1:0] e;
               int z;
               string t;
               bit bad;
               e = exp_q.pop_front(); z = z_q.pop_front(); t = tag_q.pop_front();
               bad = 0;
               for (int k = 0; k < z; k++)
                  if (out_data[k*DW +: DW] !== e[k*DW +: DW]) bad = 1;
               if (bad) begin
                  errors++;
                  for (int k = 0; k < z; k++)
                     if (out_data[k*DW +: DW] !== e[k*DW +: DW]) begin
                        $display("FAIL %s: lane %0d actual %h expected %h (z=%0d)",
                                 t, k, out_data[k*DW +: DW], e[k*DW +: DW], z);
                        break;
                     end
               end
            end
            last_out = out_data; have_last = 1;
         end else if (have_last) begin
            checks++;
            if (out_data !== last_out) begin
               errors++;
               $display("FAIL R8: output changed while idle, actual %h expected %h",
                        out_data[63:0], last_out[63:0]);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      finish_run();
   end

   initial begin
      in_data = {ZMAX{8'h5A}};
      in_vld = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      checks++;
      if (out_vld !== 1'b0 || out_data !== '0) begin
         errors++;
         $display("FAIL R1: during reset actual vld=%b expected vld=0 data=0", out_vld);
      end
      @(negedge clk);
      in_vld = 1'b0;
      rst_n = 1'b1;
      @(posedge clk); #1;
      checks++;
      if (out_vld !== 1'b0 || out_data !== '0) begin
         errors++;
         $display("FAIL R1: after reset actual vld=%b expected vld=0 data=0", out_vld);
      end

      // R3 R4 R5 R9: direct mode, all group sizes, boundary shifts
      for (int c = 0; c < 4; c++) begin
         int z;
         z = zof(2'(c));
         send(2'(c), 0, 0, 0, "R4");
         send(2'(c), 5, 0, 0, "R3");
         send(2'(c), z - 1, 0, 0, "R3");
         idle(1);
         send(2'(c), z, 0, 0, "R5");
         send(2'(c), 127, 0, 0, "R5");
         send(2'(c), z + 3, 0, 0, "R9");
         idle(2);
      end

      // R6: incremental chains, up and down through zero
      for (int c = 0; c < 4; c++) begin
         int z;
         z = zof(2'(c));
         send(2'(c), 0, 0, 1, "R7");
         send(2'(c), 7, 1, 0, "R6");
         send(2'(c), 20, 1, 0, "R6");
         send(2'(c), 3, 1, 0, "R6");
         send(2'(c), z - 1, 1, 0, "R6");
         send(2'(c), z + 2, 1, 0, "R6");
         idle(1);
         send(2'(c), 11, 1, 0, "R6");
         idle(1);
      end

      // R7: restart alone, then restart with a beat
      send(2'd1, 17, 0, 0, "R3");
      idle(1);
      restart_only();
      send(2'd1, 9, 1, 0, "R7");
      send(2'd2, 30, 0, 0, "R3");
      send(2'd2, 12, 1, 1, "R7");
      send(2'd2, 40, 1, 0, "R6");
      idle(3);

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2: missing output beats, actual %0d pending expected 0",
                  exp_q.size());
      end
      finish_run();
   end
endmodule